// File: doc/BRIEF.md
# NAND flash bus address decoder

This block lets a host with a plain asynchronous memory bus drive two NAND-style flash sockets with no special cycle types. Three high address bits pick the target: one of the two sockets or a small local register window. Two low address bits, sampled on a write, turn the cycle into a command-latch or address-latch transfer. Host read and write strobes and byte data pass through to the chosen socket. Chip enables are pure decode of the host chip select and the slot bits, so no enable register is needed.

Software treats flash device 0 as the socket at slot pattern 010 and device 1 as the socket at pattern 011. A status register in the local window returns the ready/busy state of whichever socket was touched last. It lets a driver poll for completion with an ordinary read. After a write strobe ends, the block keeps driving the flash data bus for a set number of clock cycles, which meets the device's data hold time.

Top module: `nand_bus_decoder`

## Requirements
- R1: A write cycle to a socket with address bit 5 set raises `flash_cle` for the duration of the write strobe. Bit 5 takes priority over bit 4.
- R2: A write cycle to a socket with bit 4 set and bit 5 clear raises `flash_ale`. With both bits clear, neither latch strobe rises. Read cycles never raise either latch strobe.
- R3: With `host_cs_n` low, address bits 24:22 equal to 3'b010 drive `flash_ce_n[0]` low, and 3'b011 drives `flash_ce_n[1]` low. At most one chip enable is ever active, and none is active while `host_cs_n` is high.
- R4: `flash_we_n` and `flash_re_n` follow `host_wr_n` and `host_rd_n` only while a socket is decoded. Cycles to the register window never pulse them and never enable the flash data driver.
- R5: A read cycle to a socket returns `flash_din` on `host_rdata`.
- R6: A read with bits 24:22 equal to 3'b100 and low byte 8'h02 returns bit 0 = ready (1) or busy (0) and bits 7:1 zero. Any other offset in that window reads 8'h00.
- R7: Each ready/busy input passes through two clock flops. A change on the line shows in the status bit after the second rising edge, not after the first.
- R8: The status bit follows the socket addressed by the most recent socket read or write. After reset it follows socket 0. Register-window and undecoded cycles leave that choice unchanged.
- R9: When a socket write strobe ends, `flash_doe` stays high and `flash_dout` keeps the last written byte for HOLD_CYC further rising edges. `flash_doe` then drops.
- R10: Slot patterns other than 010, 011 and 100, or a deselected bus, leave all chip enables and strobes inactive and read as 8'hFF.
- R11: During reset the flash data driver is off, both flash strobes are high and all chip enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_addr | input | 25 | Host byte address |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data to host |
| flash_rb | input | 2 | Ready/busy line per socket, 1 = ready |
| flash_din | input | 8 | Data from the flash bus |
| flash_ce_n | output | 2 | Chip enable per socket, active low |
| flash_cle | output | 1 | Command latch enable |
| flash_ale | output | 1 | Address latch enable |
| flash_re_n | output | 1 | Flash read enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_dout | output | 8 | Data to the flash bus |
| flash_doe | output | 1 | Flash data driver enable |

## Verification
Most of the block is decode logic. A wrong slot compare or a wrong latch-bit priority shows on the chip enables, the latch strobes or the read data in the same cycle, so the bench sweeps every slot pattern, cycle type and latch-bit pair. The two stored pieces of state show up later. A stale last-socket register only appears when a status read follows an access to the other socket. A wrong synchronizer depth or hold count moves an edge by whole clock cycles, so the bench samples the status bit and the data-driver enable on each cycle after the triggering event.

// File: rtl/nfd_pkg.sv
package nfd_pkg;
  // What a host cycle is aimed at
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_SOCK = 2'd1,
    TGT_REGS = 2'd2
  } nfd_tgt_e;
endpackage

// File: rtl/nfd_decode.sv
module nfd_decode
  import nfd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 25,
  parameter int unsigned SEL_LSB   = 22,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned NUM_SOCK  = 2,
  parameter int unsigned SOCK_BASE = 2,
  parameter int unsigned REG_SEL   = 4,
  parameter int unsigned SW        = 1
) (
  input  logic                cs_n,
  input  logic [ADDR_W-1:0]   addr,
  output nfd_tgt_e            tgt,
  output logic [SW-1:0]       sock_idx,
  output logic [NUM_SOCK-1:0] sock_hit
);
  logic [SEL_W-1:0] sel;
  logic             unused_addr;

  assign sel         = addr[SEL_LSB +: SEL_W];
  assign unused_addr = ^addr;

  // One comparator per socket; socket g sits at pattern SOCK_BASE+g
  for (genvar g = 0; g < NUM_SOCK; g++) begin : g_sock
    assign sock_hit[g] = !cs_n && (sel == SEL_W'(SOCK_BASE + g));
  end

  always_comb begin
    tgt      = TGT_NONE;
    sock_idx = '0;
    for (int i = 0; i < NUM_SOCK; i++) begin
      if (sock_hit[i]) begin
        tgt      = TGT_SOCK;
        sock_idx = SW'(i);
      end
    end
    if (!cs_n && (sel == SEL_W'(REG_SEL))) tgt = TGT_REGS;
  end
endmodule

// File: rtl/nfd_rb_sync.sv
module nfd_rb_sync #(
  parameter int unsigned NUM_SOCK = 2,
  parameter int unsigned STAGES   = 2,
  parameter int unsigned SW       = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SOCK-1:0] rb_in,
  input  logic                acc_en,
  input  logic [SW-1:0]       acc_idx,
  output logic                ready
);
  logic [NUM_SOCK-1:0][STAGES-1:0] chain_q, chain_d;
  logic [SW-1:0]                   last_q, last_d;

  always_comb begin
    for (int i = 0; i < NUM_SOCK; i++) begin
      chain_d[i] = {chain_q[i][STAGES-2:0], rb_in[i]};
    end
    last_d = acc_en ? acc_idx : last_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= '0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign ready = chain_q[last_q][STAGES-1];

  // R8: socket choice only moves on a socket access
  p_last_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(last_q));
endmodule

// File: rtl/nfd_hold.sv
module nfd_hold #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned HOLD_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_act,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] dout,
  output logic              doe
);
  localparam int unsigned CW = $clog2(HOLD_CYC + 1);

  logic [CW-1:0]     cnt_q, cnt_d;
  logic [DATA_W-1:0] data_q;
  logic              data_en;

  assign data_en = wr_act;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_act)               cnt_d = CW'(HOLD_CYC);
    else if (cnt_q != '0)     cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= wdata;
  end

  assign dout = wr_act ? wdata : data_q;
  assign doe  = wr_act || (cnt_q != '0);

  // R9: driver still on the edge after a write strobe ends
  p_hold_after_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_act) && !wr_act) |-> doe);
  // R9: held byte does not move during the hold window
  p_dout_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (doe && !wr_act && $past(doe) && !$past(wr_act)) |-> $stable(dout));
endmodule

// File: rtl/nand_bus_decoder.sv
module nand_bus_decoder
  import nfd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 25,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_SOCK  = 2,
  parameter int unsigned SEL_LSB   = 22,
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned SOCK_BASE = 2,
  parameter int unsigned REG_SEL   = 4,
  parameter int unsigned CLE_BIT   = 5,
  parameter int unsigned ALE_BIT   = 4,
  parameter int unsigned REG_OFS_W = 8,
  parameter int unsigned STAT_OFS  = 2,
  parameter int unsigned HOLD_CYC  = 3,
  parameter int unsigned STAGES    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_cs_n,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic                host_rd_n,
  input  logic                host_wr_n,
  input  logic [DATA_W-1:0]   host_wdata,
  output logic [DATA_W-1:0]   host_rdata,
  input  logic [NUM_SOCK-1:0] flash_rb,
  input  logic [DATA_W-1:0]   flash_din,
  output logic [NUM_SOCK-1:0] flash_ce_n,
  output logic                flash_cle,
  output logic                flash_ale,
  output logic                flash_re_n,
  output logic                flash_we_n,
  output logic [DATA_W-1:0]   flash_dout,
  output logic                flash_doe
);
  localparam int unsigned SW = (NUM_SOCK > 1) ? $clog2(NUM_SOCK) : 1;

  nfd_tgt_e            tgt;
  logic [SW-1:0]       sock_idx;
  logic [NUM_SOCK-1:0] sock_hit;
  logic                sock_sel, wr_act, rd_act, acc_en, ready, stat_hit;

  nfd_decode #(
    .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .NUM_SOCK(NUM_SOCK),
    .SOCK_BASE(SOCK_BASE), .REG_SEL(REG_SEL), .SW(SW)
  ) i_decode (
    .cs_n(host_cs_n), .addr(host_addr), .tgt(tgt),
    .sock_idx(sock_idx), .sock_hit(sock_hit)
  );

  assign sock_sel = (tgt == TGT_SOCK);
  assign wr_act   = sock_sel && !host_wr_n;
  assign rd_act   = sock_sel && !host_rd_n;
  assign acc_en   = wr_act || rd_act;

  nfd_rb_sync #(.NUM_SOCK(NUM_SOCK), .STAGES(STAGES), .SW(SW)) i_rb_sync (
    .clk(clk), .rst_n(rst_n), .rb_in(flash_rb), .acc_en(acc_en),
    .acc_idx(sock_idx), .ready(ready)
  );

  nfd_hold #(.DATA_W(DATA_W), .HOLD_CYC(HOLD_CYC)) i_hold (
    .clk(clk), .rst_n(rst_n), .wr_act(wr_act), .wdata(host_wdata),
    .dout(flash_dout), .doe(flash_doe)
  );

  assign flash_ce_n = ~sock_hit;
  assign flash_we_n = !wr_act;
  assign flash_re_n = !rd_act;
  assign flash_cle  = wr_act && host_addr[CLE_BIT];
  assign flash_ale  = wr_act && !host_addr[CLE_BIT] && host_addr[ALE_BIT];

  assign stat_hit = (host_addr[REG_OFS_W-1:0] == REG_OFS_W'(STAT_OFS));

  always_comb begin
    unique case (tgt)
      TGT_SOCK: host_rdata = flash_din;
      TGT_REGS: host_rdata = stat_hit ? {{(DATA_W-1){1'b0}}, ready} : '0;
      default:  host_rdata = '1;
    endcase
  end

  // R2: latch strobes never both high
  p_cle_ale_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(flash_cle && flash_ale));
  // R3: one chip enable at most
  p_ce_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~flash_ce_n));
  // R4: a flash strobe needs an active chip enable
  p_strobe_needs_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n || !flash_re_n) |-> !(&flash_ce_n));
  // R10: no chip enable, no flash activity
  p_idle_when_unselected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (&flash_ce_n) |-> (flash_we_n && flash_re_n && !flash_cle && !flash_ale));
endmodule

// File: tb/test_nand_bus_decoder.sv
module test_nand_bus_decoder;
  localparam int HOLD = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_cs_n, host_rd_n, host_wr_n;
  logic [24:0] host_addr;
  logic [7:0]  host_wdata, host_rdata, flash_din, flash_dout;
  logic [1:0]  flash_rb, flash_ce_n;
  logic        flash_cle, flash_ale, flash_re_n, flash_we_n, flash_doe;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  nand_bus_decoder #(.HOLD_CYC(HOLD)) i_nand_bus_decoder (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_addr(host_addr),
    .host_rd_n(host_rd_n), .host_wr_n(host_wr_n), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .flash_rb(flash_rb), .flash_din(flash_din),
    .flash_ce_n(flash_ce_n), .flash_cle(flash_cle), .flash_ale(flash_ale),
    .flash_re_n(flash_re_n), .flash_we_n(flash_we_n),
    .flash_dout(flash_dout), .flash_doe(flash_doe)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one host cycle just after a falling edge, then settle
  task automatic drive(input logic cs_n, input logic [2:0] sel, input logic [1:0] lo,
                       input logic [7:0] ofs, input logic rd_n, input logic wr_n,
                       input logic [7:0] wd);
    @(negedge clk);
    host_cs_n  = cs_n;
    host_addr  = {sel, 14'd0, ofs} | (25'(lo) << 4);
    host_rd_n  = rd_n;
    host_wr_n  = wr_n;
    host_wdata = wd;
    #2;
  endtask

  task automatic idle();
    drive(1'b1, 3'd0, 2'd0, 8'h00, 1'b1, 1'b1, 8'h00);
  endtask

  task automatic read_status(output logic [7:0] v);
    drive(1'b0, 3'd4, 2'd0, 8'h02, 1'b0, 1'b1, 8'h00);
    v = host_rdata;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] st;
    rst_n = 1'b0; host_cs_n = 1'b1; host_addr = '0; host_rd_n = 1'b1;
    host_wr_n = 1'b1; host_wdata = '0; flash_din = 8'h5A; flash_rb = 2'b11;
    repeat (3) @(negedge clk);
    #2;
    // R11: reset state
    chk("R11 doe in reset", flash_doe, 1'b0);
    chk("R11 strobes in reset", {flash_we_n, flash_re_n}, 2'b11);
    chk("R11 ce_n in reset", flash_ce_n, 2'b11);
    chk("R10 rdata deselected", host_rdata, 8'hFF);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Sweep: selector x cycle type x latch bits
    for (int s = 0; s < 8; s++) begin
      for (int op = 0; op < 3; op++) begin
        for (int lo = 0; lo < 4; lo++) begin
          logic hit, regw;
          logic [7:0] exp_rd;
          flash_din = 8'hA0 ^ 8'(s * 7 + lo);
          drive(1'b0, 3'(s), 2'(lo), 8'h02, !(op == 1), !(op == 2), 8'h00);
          hit  = (s == 2) || (s == 3);
          regw = (s == 4);
          chk("R3 ce_n decode", flash_ce_n, {!(s == 3), !(s == 2)});
          chk("R1 cle", flash_cle, hit && op == 2 && lo[1]);
          chk("R2 ale", flash_ale, hit && op == 2 && !lo[1] && lo[0]);
          chk("R4 we_n", flash_we_n, !(hit && op == 2));
          chk("R4 re_n", flash_re_n, !(hit && op == 1));
          if (hit)       exp_rd = flash_din;
          else if (regw) exp_rd = (lo == 0) ? 8'h01 : 8'h00;
          else           exp_rd = 8'hFF;
          chk(hit ? "R5 socket read" : (regw ? "R6 register read" : "R10 undecoded read"),
              host_rdata, exp_rd);
        end
      end
    end

    // R3 / R10: deselected bus decodes nothing
    for (int s = 0; s < 8; s++) begin
      drive(1'b1, 3'(s), 2'd3, 8'h02, 1'b0, 1'b0, 8'h00);
      chk("R3 no ce when deselected", flash_ce_n, 2'b11);
      chk("R10 strobes when deselected", {flash_we_n, flash_re_n, flash_cle, flash_ale}, 4'b1100);
      chk("R10 rdata when deselected", host_rdata, 8'hFF);
    end
    idle();
    repeat (HOLD + 1) idle();

    // R4: register-window write leaves data driver off
    drive(1'b0, 3'd4, 2'd0, 8'h02, 1'b1, 1'b0, 8'h77);
    chk("R4 no doe on register write", flash_doe, 1'b0);
    idle();
    chk("R4 no doe after register write", flash_doe, 1'b0);

    // R9: hold after socket write
    drive(1'b0, 3'd2, 2'd0, 8'h00, 1'b1, 1'b0, 8'h3C);
    chk("R9 dout during write", flash_dout, 8'h3C);
    chk("R9 doe during write", flash_doe, 1'b1);
    for (int k = 0; k <= HOLD; k++) begin
      idle();
      chk("R9 doe hold window", flash_doe, k < HOLD);
      if (k < HOLD) chk("R9 dout held", flash_dout, 8'h3C);
    end

    // R6 other register offset reads zero
    drive(1'b0, 3'd4, 2'd0, 8'h03, 1'b0, 1'b1, 8'h00);
    chk("R6 other offset", host_rdata, 8'h00);

    // R8: follows last socket; socket 0 busy, socket 1 ready
    flash_rb = 2'b10;
    repeat (3) idle();
    read_status(st);
    chk("R8 socket0 after reset-era accesses", st, 8'h00);
    drive(1'b0, 3'd3, 2'd0, 8'h00, 1'b0, 1'b1, 8'h00);
    read_status(st);
    chk("R8 follows socket1", st, 8'h01);
    drive(1'b0, 3'd5, 2'd0, 8'h00, 1'b1, 1'b0, 8'h00);
    drive(1'b0, 3'd4, 2'd0, 8'h10, 1'b1, 1'b0, 8'h00);
    read_status(st);
    chk("R8 kept after non-socket cycles", st, 8'h01);
    drive(1'b0, 3'd2, 2'd0, 8'h00, 1'b1, 1'b0, 8'h00);
    read_status(st);
    chk("R8 follows socket0 write", st, 8'h00);
    drive(1'b0, 3'd3, 2'd1, 8'h00, 1'b1, 1'b0, 8'h00);
    read_status(st);
    chk("R8 back to socket1", st, 8'h01);

    // R7: two-flop delay on socket 1 going busy
    @(negedge clk);
    flash_rb[1] = 1'b0;
    host_cs_n = 1'b0; host_addr = {3'd4, 14'd0, 8'h02}; host_rd_n = 1'b0; host_wr_n = 1'b1;
    #2;
    chk("R7 no change before edges", host_rdata, 8'h01);
    @(negedge clk); #2;
    chk("R7 unchanged after one edge", host_rdata, 8'h01);
    @(negedge clk); #2;
    chk("R7 busy after second edge", host_rdata, 8'h00);
    @(negedge clk);
    flash_rb[1] = 1'b1;
    #2;
    @(negedge clk); #2;
    chk("R7 ready not yet after one edge", host_rdata, 8'h00);
    @(negedge clk); #2;
    chk("R7 ready after second edge", host_rdata, 8'h01);
    idle();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule